// File: doc/BRIEF.md
# Tagged memory access unit

This unit carries out the doubleword memory operations of a 64-bit core in which every memory word holds 64 data bits plus a 2-bit integrity tag. It accepts one instruction per cycle together with the instruction's 1-bit privilege mark (1 = sensitive, 0 = ordinary) and the two source register values. It decodes the instruction, forms the effective address and drives a synchronous 66-bit memory port. One fixed number of cycles later it reports completion, a register write-back (data and tag) or a fault.

Two custom instructions share one opcode. One loads a word with its tag into a register and the other stores a word with a tag. A side input picks between them. Plain doubleword loads and stores are handled too and carry no tag. A sensitive store-with-tag marks the word as protected. Every other store leaves the word unprotected. A sensitive load-with-tag refuses any word that is not marked protected. A return address saved this way therefore cannot be replaced by an ordinary store without the next sensitive reload faulting.

Top module: `tagmem_unit`

## Requirements
- R1: Decoding. Opcode 1010111 with funct3 000 is a tagged access. When `store_sel_i` is 0 it is a tagged load (I-type fields). When `store_sel_i` is 1 it is a tagged store (S-type fields). Opcode 0000011 with funct3 011 is a plain load and opcode 0100011 with funct3 011 is a plain store. For plain accesses `store_sel_i` is ignored. `rs1_idx_o` shows instruction bits 19:15 and `rs2_idx_o` shows bits 24:20.
- R2: Addressing. The effective address is rs1 plus a sign-extended 12-bit immediate. For loads the immediate is bits 31:20. For stores it is bits 31:25 over bits 11:7. `mem_addr_o` is the effective address shifted right by 3.
- R3: A memory word keeps its tag in bits 65:64 and its data in bits 63:0. A tagged store from a sensitive instruction writes tag 01 with the rs2 value.
- R4: A tagged store from an ordinary instruction, and any plain store, writes tag 00 with the rs2 value.
- R5: A sensitive tagged load of a word whose tag is not 01 completes with fault cause 2 (tag) and writes no register.
- R6: A sensitive tagged load of a word tagged 01 writes back the data with tag 01. An ordinary tagged load writes back the data and the stored tag without any check.
- R7: A plain load writes back the data with tag 00 and never checks the tag, whatever the privilege bit.
- R8: A memory access whose effective address has any of bits 2:0 set completes with fault cause 1 (alignment). It makes no memory access and no write-back, so the addressed word is left unchanged.
- R9: Any other instruction completes with fault cause 3 (illegal) and makes no memory access.
- R10: Each accepted instruction has its memory request presented in the issue cycle. Its result (`done_o`) appears after the second rising edge following issue. Instructions may issue on back-to-back cycles. A load issued right after a store to the same word returns the newly stored word.
- R11: A load whose destination index is 0 completes without a fault and with `wb_en_o` low.
- R12: While reset is held, `done_o`, `wb_en_o` and `fault_o` are low. `fault_o` is high exactly when `fault_cause_o` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An instruction is issued this cycle |
| instr_i | input | 32 | Instruction word |
| store_sel_i | input | 1 | Picks store (1) or load (0) for the tagged opcode |
| priv_i | input | 1 | Privilege mark of the instruction, 1 = sensitive |
| rs1_idx_o | output | 5 | Base register index for the register file |
| rs2_idx_o | output | 5 | Store source register index for the register file |
| rs1_val_i | input | 64 | Base register value |
| rs2_val_i | input | 64 | Store source register value |
| mem_en_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 61 | Doubleword address |
| mem_wdata_o | output | 66 | Word to write, tag in bits 65:64 |
| mem_rdata_i | input | 66 | Word read, valid the cycle after the request |
| done_o | output | 1 | An instruction has completed |
| wb_en_o | output | 1 | Register write-back request |
| wb_rd_o | output | 5 | Destination register index |
| wb_data_o | output | 64 | Data to write back |
| wb_tag_o | output | 2 | Tag to write back |
| fault_o | output | 1 | The completed instruction faulted |
| fault_cause_o | output | 2 | 0 none, 1 alignment, 2 tag, 3 illegal |

## Verification
The unit has fixed widths (64-bit data, 2-bit tag, 12-bit immediates), and the bench builds it with those. The bench pairs it with a 64-word memory that decodes only the low six doubleword address bits. That lets the largest positive and most negative immediates land on real words while the expected values stay simple. The behavioural model replays every issued instruction against its own shadow memory in program order. Protect-then-overwrite sequences, store-then-load back-to-back pairs and faulting stores followed by reloads are all compared on every clock.

// File: rtl/tm_pkg.sv
package tm_pkg;
    localparam int XLEN      = 64;
    localparam int TAG_W     = 2;
    localparam int WORD_W    = XLEN + TAG_W;
    localparam int INSTR_W   = 32;
    localparam int REG_IDX_W = 5;
    localparam int IMM_W     = 12;
    localparam int DW_SHIFT  = 3;
    localparam int WADDR_W   = XLEN - DW_SHIFT;

    localparam logic [6:0] OPC_TAGGED = 7'b1010111;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [2:0] F3_TAGGED  = 3'b000;
    localparam logic [2:0] F3_DWORD   = 3'b011;

    localparam logic [TAG_W-1:0] TAG_PLAIN = 2'b00;
    localparam logic [TAG_W-1:0] TAG_SENS  = 2'b01;

    typedef enum logic [2:0] {
        OP_NONE, OP_TLOAD, OP_TSTORE, OP_LOAD, OP_STORE, OP_BAD
    } op_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_ALIGN   = 2'd1,
        CAUSE_TAG     = 2'd2,
        CAUSE_ILLEGAL = 2'd3
    } cause_e;

    typedef struct packed {
        op_e                  op;
        logic                 priv;
        logic [REG_IDX_W-1:0] rd;
        logic [XLEN-1:0]      imm;
    } dec_t;

    typedef struct packed {
        logic                 valid;
        op_e                  op;
        logic                 priv;
        logic [REG_IDX_W-1:0] rd;
        cause_e               cause;
    } stage_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic op_is_load(input op_e o);
        return (o == OP_TLOAD) || (o == OP_LOAD);
    endfunction

    function automatic logic op_is_store(input op_e o);
        return (o == OP_TSTORE) || (o == OP_STORE);
    endfunction
endpackage

// File: rtl/tm_decode.sv
module tm_decode
    import tm_pkg::*;
(
    input  logic                 valid_i,
    input  logic [INSTR_W-1:0]   instr_i,
    input  logic                 store_sel_i,
    input  logic                 priv_i,
    output logic [REG_IDX_W-1:0] rs1_idx_o,
    output logic [REG_IDX_W-1:0] rs2_idx_o,
    output dec_t                 dec_o
);
    logic [6:0] opc;
    logic [2:0] f3;
    op_e        op;

    assign opc       = instr_i[6:0];
    assign f3        = instr_i[14:12];
    assign rs1_idx_o = instr_i[19:15];
    assign rs2_idx_o = instr_i[24:20];

    always_comb begin
        op = OP_NONE;
        if (valid_i) begin
            if (opc == OPC_TAGGED && f3 == F3_TAGGED)
                op = store_sel_i ? OP_TSTORE : OP_TLOAD;
            else if (opc == OPC_LOAD && f3 == F3_DWORD)
                op = OP_LOAD;
            else if (opc == OPC_STORE && f3 == F3_DWORD)
                op = OP_STORE;
            else
                op = OP_BAD;
        end
    end

    always_comb begin
        dec_o.op   = op;
        dec_o.priv = priv_i;
        dec_o.rd   = instr_i[11:7];
        if (op_is_store(op))
            dec_o.imm = sext_imm({instr_i[31:25], instr_i[11:7]});
        else
            dec_o.imm = sext_imm(instr_i[31:20]);
    end
endmodule

// File: rtl/tm_agu.sv
module tm_agu
    import tm_pkg::*;
(
    input  logic [XLEN-1:0]    base_i,
    input  logic [XLEN-1:0]    offset_i,
    output logic [WADDR_W-1:0] waddr_o,
    output logic               misaligned_o
);
    logic [XLEN-1:0] ea;

    assign ea           = base_i + offset_i;
    assign waddr_o      = ea[XLEN-1:DW_SHIFT];
    assign misaligned_o = |ea[DW_SHIFT-1:0];
endmodule

// File: rtl/tm_tagpolicy.sv
module tm_tagpolicy
    import tm_pkg::*;
(
    input  op_e              st_op_i,
    input  logic             st_priv_i,
    output logic [TAG_W-1:0] st_tag_o,
    input  op_e              ld_op_i,
    input  logic             ld_priv_i,
    input  logic [TAG_W-1:0] ld_word_tag_i,
    output logic [TAG_W-1:0] ld_tag_o,
    output cause_e           ld_cause_o
);
    // Only a sensitive tagged store may raise the protection level.
    always_comb begin
        st_tag_o = TAG_PLAIN;
        if (st_op_i == OP_TSTORE && st_priv_i)
            st_tag_o = TAG_SENS;
    end

    // A sensitive tagged load demands a protected word; plain loads drop tags.
    always_comb begin
        ld_tag_o   = TAG_PLAIN;
        ld_cause_o = CAUSE_NONE;
        if (ld_op_i == OP_TLOAD) begin
            if (ld_priv_i && ld_word_tag_i != TAG_SENS)
                ld_cause_o = CAUSE_TAG;
            else
                ld_tag_o = ld_word_tag_i;
        end
    end
endmodule

// File: rtl/tagmem_unit.sv
module tagmem_unit
    import tm_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 valid_i,
    input  logic [INSTR_W-1:0]   instr_i,
    input  logic                 store_sel_i,
    input  logic                 priv_i,
    output logic [REG_IDX_W-1:0] rs1_idx_o,
    output logic [REG_IDX_W-1:0] rs2_idx_o,
    input  logic [XLEN-1:0]      rs1_val_i,
    input  logic [XLEN-1:0]      rs2_val_i,
    output logic                 mem_en_o,
    output logic                 mem_we_o,
    output logic [WADDR_W-1:0]   mem_addr_o,
    output logic [WORD_W-1:0]    mem_wdata_o,
    input  logic [WORD_W-1:0]    mem_rdata_i,
    output logic                 done_o,
    output logic                 wb_en_o,
    output logic [REG_IDX_W-1:0] wb_rd_o,
    output logic [XLEN-1:0]      wb_data_o,
    output logic [TAG_W-1:0]     wb_tag_o,
    output logic                 fault_o,
    output logic [1:0]           fault_cause_o
);
    dec_t             dec;
    logic             misaligned;
    logic             is_mem;
    cause_e           issue_cause;
    logic [TAG_W-1:0] st_tag;
    stage_t           s1;
    logic [TAG_W-1:0] ld_tag;
    cause_e           ld_cause;
    cause_e           fin_cause;

    tm_decode u_decode (
        .valid_i     (valid_i),
        .instr_i     (instr_i),
        .store_sel_i (store_sel_i),
        .priv_i      (priv_i),
        .rs1_idx_o   (rs1_idx_o),
        .rs2_idx_o   (rs2_idx_o),
        .dec_o       (dec)
    );

    tm_agu u_agu (
        .base_i       (rs1_val_i),
        .offset_i     (dec.imm),
        .waddr_o      (mem_addr_o),
        .misaligned_o (misaligned)
    );

    tm_tagpolicy u_policy (
        .st_op_i       (dec.op),
        .st_priv_i     (dec.priv),
        .st_tag_o      (st_tag),
        .ld_op_i       (s1.op),
        .ld_priv_i     (s1.priv),
        .ld_word_tag_i (mem_rdata_i[WORD_W-1:XLEN]),
        .ld_tag_o      (ld_tag),
        .ld_cause_o    (ld_cause)
    );

    // Issue stage: request goes out combinationally, faults block it.
    assign is_mem = op_is_load(dec.op) || op_is_store(dec.op);

    always_comb begin
        issue_cause = CAUSE_NONE;
        if (dec.op == OP_BAD)
            issue_cause = CAUSE_ILLEGAL;
        else if (is_mem && misaligned)
            issue_cause = CAUSE_ALIGN;
    end

    assign mem_en_o    = is_mem && !misaligned;
    assign mem_we_o    = op_is_store(dec.op) && !misaligned;
    assign mem_wdata_o = {st_tag, rs2_val_i};

    // Response stage: waits one cycle for the memory read data.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s1.valid <= 1'b0;
            s1.op    <= OP_NONE;
            s1.priv  <= 1'b0;
            s1.rd    <= '0;
            s1.cause <= CAUSE_NONE;
        end else begin
            s1.valid <= valid_i;
            s1.op    <= dec.op;
            s1.priv  <= dec.priv;
            s1.rd    <= dec.rd;
            s1.cause <= issue_cause;
        end
    end

    always_comb begin
        fin_cause = s1.cause;
        if (s1.cause == CAUSE_NONE && op_is_load(s1.op))
            fin_cause = ld_cause;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            done_o        <= 1'b0;
            wb_en_o       <= 1'b0;
            wb_rd_o       <= '0;
            wb_data_o     <= '0;
            wb_tag_o      <= TAG_PLAIN;
            fault_o       <= 1'b0;
            fault_cause_o <= CAUSE_NONE;
        end else begin
            done_o        <= s1.valid;
            wb_en_o       <= s1.valid && op_is_load(s1.op) &&
                             fin_cause == CAUSE_NONE && s1.rd != '0;
            wb_rd_o       <= s1.rd;
            wb_data_o     <= mem_rdata_i[XLEN-1:0];
            wb_tag_o      <= ld_tag;
            fault_o       <= s1.valid && fin_cause != CAUSE_NONE;
            fault_cause_o <= s1.valid ? fin_cause : CAUSE_NONE;
        end
    end

    assert_done_latency_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i |-> ##2 done_o);

    assert_fault_blocks_wb_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        fault_o |-> !wb_en_o);

    assert_x0_untouched_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        wb_en_o |-> (done_o && wb_rd_o != '0));

    assert_store_tag_bound_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_we_o |-> !mem_wdata_o[WORD_W-1]);

    assert_write_needs_access_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_we_o |-> mem_en_o);

    assert_cause_flag_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        fault_o == (fault_cause_o != 2'd0));
endmodule

// File: tb/test_tagmem_unit.sv
module test_tagmem_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid, store_sel, priv;
    logic [31:0] instr;
    logic [4:0]  rs1_idx, rs2_idx;
    logic [63:0] rs1_val, rs2_val;
    logic        mem_en, mem_we;
    logic [60:0] mem_addr;
    logic [65:0] mem_wdata;
    logic [65:0] mem_rdata;
    logic        done, wb_en, fault;
    logic [4:0]  wb_rd;
    logic [63:0] wb_data;
    logic [1:0]  wb_tag, fault_cause;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tagmem_unit i_tagmem_unit (
        .clk_i(clk), .rst_i(rst), .valid_i(valid), .instr_i(instr),
        .store_sel_i(store_sel), .priv_i(priv),
        .rs1_idx_o(rs1_idx), .rs2_idx_o(rs2_idx),
        .rs1_val_i(rs1_val), .rs2_val_i(rs2_val),
        .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .done_o(done), .wb_en_o(wb_en), .wb_rd_o(wb_rd), .wb_data_o(wb_data),
        .wb_tag_o(wb_tag), .fault_o(fault), .fault_cause_o(fault_cause)
    );

    // Bench memory: 64 words, synchronous, one-cycle read.
    logic [65:0] bmem [64] = '{default: '0};
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) bmem[mem_addr[5:0]] <= mem_wdata;
            else        mem_rdata <= bmem[mem_addr[5:0]];
        end
    end

    // Reference model state.
    logic [65:0] shadow [64] = '{default: '0};

    typedef struct {
        bit        done;
        bit [1:0]  cause;
        bit        wben;
        bit [4:0]  rd;
        bit [63:0] data;
        bit [1:0]  tag;
        string     req;
    } exp_t;
    exp_t q[$];

    localparam bit [6:0] OT = 7'b1010111;
    localparam bit [6:0] OL = 7'b0000011;
    localparam bit [6:0] OS = 7'b0100011;

    function automatic logic [31:0] enc_i(bit [6:0] opc, bit [2:0] f3, bit [4:0] rd,
                                          bit [4:0] rs1, bit [11:0] imm);
        return {imm, rs1, f3, rd, opc};
    endfunction

    function automatic logic [31:0] enc_s(bit [6:0] opc, bit [2:0] f3, bit [4:0] rs2,
                                          bit [4:0] rs1, bit [11:0] imm);
        return {imm[11:5], rs2, rs1, f3, imm[4:0], opc};
    endfunction

    task automatic check_out();
        exp_t e;
        bit ok;
        e = q.pop_front();
        checks++;
        ok = (done === e.done);
        if (e.done)
            ok = ok && (fault_cause === e.cause) && (fault === (e.cause != 0)) &&
                 (wb_en === e.wben);
        if (e.done && e.wben)
            ok = ok && (wb_rd === e.rd) && (wb_data === e.data) && (wb_tag === e.tag);
        if (!ok) begin
            errors++;
            $display("FAIL %s: got done=%b cause=%0d wb=%b rd=%0d data=%h tag=%b, expected done=%b cause=%0d wb=%b rd=%0d data=%h tag=%b",
                     e.req, done, fault_cause, wb_en, wb_rd, wb_data, wb_tag,
                     e.done, e.cause, e.wben, e.rd, e.data, e.tag);
        end
    endtask

    task automatic step(input bit v, input logic [31:0] ins, input bit ssel, input bit pv,
                        input logic [63:0] a, input logic [63:0] b, input string req);
        exp_t e;
        bit [6:0] opc;
        bit [2:0] f3;
        int kind;
        bit [11:0] imm;
        bit [63:0] ea;
        bit men;
        bit [65:0] w;
        @(negedge clk);
        check_out();
        e = '{done: v, cause: 0, wben: 0, rd: ins[11:7], data: 0, tag: 0, req: req};
        men = 0;
        if (v) begin
            opc = ins[6:0];
            f3  = ins[14:12];
            if (opc == OT && f3 == 3'b000) kind = ssel ? 2 : 1;
            else if (opc == OL && f3 == 3'b011) kind = 3;
            else if (opc == OS && f3 == 3'b011) kind = 4;
            else kind = 5;
            imm = (kind == 2 || kind == 4) ? {ins[31:25], ins[11:7]} : ins[31:20];
            ea  = a + {{52{imm[11]}}, imm};
            if (kind == 5) e.cause = 3;
            else if (ea[2:0] != 0) e.cause = 1;
            else begin
                men = 1;
                case (kind)
                    2: shadow[ea[8:3]] = {(pv ? 2'b01 : 2'b00), b};
                    4: shadow[ea[8:3]] = {2'b00, b};
                    1: begin
                        w = shadow[ea[8:3]];
                        if (pv && w[65:64] != 2'b01) e.cause = 2;
                        else begin
                            e.wben = (ins[11:7] != 0);
                            e.data = w[63:0];
                            e.tag  = w[65:64];
                        end
                    end
                    default: begin
                        w = shadow[ea[8:3]];
                        e.wben = (ins[11:7] != 0);
                        e.data = w[63:0];
                        e.tag  = 2'b00;
                    end
                endcase
            end
        end
        q.push_back(e);
        valid = v; instr = ins; store_sel = ssel; priv = pv; rs1_val = a; rs2_val = b;
        #1;
        checks++;
        if (mem_en !== men || (v && (rs1_idx !== ins[19:15] || rs2_idx !== ins[24:20]))) begin
            errors++;
            $display("FAIL %s (port): got mem_en=%b rs1=%0d rs2=%0d, expected mem_en=%b rs1=%0d rs2=%0d",
                     req, mem_en, rs1_idx, rs2_idx, men, ins[19:15], ins[24:20]);
        end
    endtask

    task automatic idle();
        step(0, 32'h0, 0, 0, 64'h0, 64'h0, "R10 idle");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R10 watchdog: got no end, expected end");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; valid = 0; instr = 0; store_sel = 0; priv = 0; rs1_val = 0; rs2_val = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (done !== 1'b0 || wb_en !== 1'b0 || fault !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset: got done=%b wb=%b fault=%b, expected 0 0 0", done, wb_en, fault);
        end
        rst = 0;
        q.push_back('{done: 0, cause: 0, wben: 0, rd: 0, data: 0, tag: 0, req: "R12"});
        q.push_back('{done: 0, cause: 0, wben: 0, rd: 0, data: 0, tag: 0, req: "R12"});

        // R4: plain store then R7 plain load (store_sel ignored, R1)
        step(1, enc_s(OS, 3'b011, 5'd2, 5'd1, 12'd8), 0, 0, 64'h100, 64'hA5A5_0000_1111_2222, "R4 plain store");
        step(1, enc_i(OL, 3'b011, 5'd3, 5'd1, 12'd8), 1, 1, 64'h100, 0, "R7 plain load after store R10");
        // R3: sensitive tagged store, negative S-type immediate (R2)
        step(1, enc_s(OT, 3'b000, 5'd4, 5'd1, -12'sd8), 1, 1, 64'h40, 64'hBEEF_0000_CAFE_0001, "R3 sensitive store");
        step(1, enc_i(OT, 3'b000, 5'd5, 5'd1, 12'd8), 0, 1, 64'h30, 0, "R6 sensitive load passes");
        step(1, enc_i(OT, 3'b000, 5'd6, 5'd1, 12'd8), 0, 0, 64'h30, 0, "R6 ordinary tagged load");
        // R4: ordinary tagged store overwrites protected word
        step(1, enc_s(OT, 3'b000, 5'd7, 5'd1, 12'd0), 1, 0, 64'h38, 64'h0BAD_0BAD_0BAD_0BAD, "R4 ordinary tagged store");
        step(1, enc_i(OT, 3'b000, 5'd8, 5'd1, 12'd0), 0, 1, 64'h38, 0, "R5 tag mismatch");
        step(1, enc_i(OT, 3'b000, 5'd9, 5'd1, 12'd0), 0, 0, 64'h38, 0, "R6 ordinary reads tag 00");
        step(1, enc_i(OL, 3'b011, 5'd10, 5'd1, 12'd0), 0, 1, 64'h38, 0, "R7 sensitive plain load unchecked");
        idle();
        // R8: misaligned store must not touch memory
        step(1, enc_s(OT, 3'b000, 5'd4, 5'd1, 12'd4), 1, 1, 64'h38, 64'h1234, "R8 misaligned store");
        step(1, enc_i(OT, 3'b000, 5'd11, 5'd1, 12'd0), 0, 0, 64'h38, 0, "R8 word unchanged");
        step(1, enc_i(OL, 3'b011, 5'd12, 5'd1, 12'd1), 0, 0, 64'h100, 0, "R8 misaligned load");
        // R9: illegal encodings
        step(1, 32'h0020_81B3, 0, 0, 64'h0, 0, "R9 illegal opcode");
        step(1, enc_i(OL, 3'b010, 5'd3, 5'd1, 12'd0), 0, 0, 64'h0, 0, "R9 wrong funct3");
        step(1, enc_i(OT, 3'b001, 5'd3, 5'd1, 12'd0), 1, 1, 64'h0, 0, "R9 tagged wrong funct3");
        // R11: destination x0
        step(1, enc_i(OT, 3'b000, 5'd0, 5'd1, 12'd8), 0, 0, 64'h100, 0, "R11 x0 load");
        // R10: back-to-back protect then reload
        step(1, enc_s(OT, 3'b000, 5'd2, 5'd1, 12'd0), 1, 1, 64'h80, 64'hD00D_F00D_0000_0042, "R3 store back-to-back");
        step(1, enc_i(OT, 3'b000, 5'd13, 5'd1, 12'd0), 0, 1, 64'h80, 0, "R10 load after store");
        // R5: sensitive load of a plain-stored word
        step(1, enc_i(OT, 3'b000, 5'd14, 5'd1, 12'd8), 0, 1, 64'h100, 0, "R5 plain word refused");
        // R2: immediate extremes
        step(1, enc_s(OS, 3'b011, 5'd2, 5'd1, 12'h7F8), 0, 0, 64'h0, 64'h7777_8888_9999_AAAA, "R2 max store imm");
        step(1, enc_i(OL, 3'b011, 5'd15, 5'd1, 12'h7F8), 0, 0, 64'h0, 0, "R2 max load imm");
        step(1, enc_i(OT, 3'b000, 5'd16, 5'd1, 12'h800), 0, 0, 64'h900, 0, "R2 min load imm");
        step(1, enc_s(OT, 3'b000, 5'd2, 5'd1, 12'h800), 1, 1, 64'h9F0, 64'h5555, "R2 min store imm");
        step(1, enc_i(OT, 3'b000, 5'd17, 5'd1, 12'h1F0), 0, 1, 64'h0, 0, "R2 reload at 0x1F0");
        idle();
        idle();
        idle();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule